// File: doc/BRIEF.md
# I2C byte wait and acknowledge sequencer

This block is the per-byte timing core of an I2C controller that can act as master or slave. It brings the SCL line into the system clock domain, counts SCL falling edges within each byte, and picks the clock after which the byte-done interrupt fires and SCL is held low. That point is either the eighth clock (before the acknowledge bit) or the ninth clock (after it). It also pulls SDA low during the acknowledge clock when an acknowledge is due.

Software picks the wait point for data bytes with a wait-select bit. It enables the automatic acknowledge with an ack-enable bit. Both bits are loaded through a write strobe. During the address byte the block overrides both bits from the mode and the address-recognition flags. Software ends each wait with a one-cycle release strobe. Any start or stop detection puts the clock count back to the start of a byte.

Top module: `i2c_byte_seq`

## Requirements
- R1: After reset, `scl_hold`, `sda_pull` and `irq` are 0 and both control bits are 0, so a data byte waits at clock 8 with no acknowledge.
- R2: In a data byte (`addr_phase`=0) with wait-select 0, `irq` pulses and `scl_hold` rises three system clocks after the 8th SCL falling edge at `scl_in`, and not at the 9th.
- R3: In a data byte with wait-select 1, the interrupt and the wait happen at the 9th SCL falling edge only.
- R4: In an address byte with `is_master`=1, the wait happens at the 9th falling edge whatever the wait-select bit is.
- R5: In an address byte as slave with `addr_match`=1, SDA is pulled low during clock 9 and the wait happens at the 9th falling edge. With no match and no flag set, there is no interrupt and no acknowledge.
- R6: In an address byte with `ext_code`=1, the wait happens at the 8th falling edge, and the acknowledge follows the ack-enable bit.
- R7: In an address byte with `gen_call`=1, SDA is acknowledged and the wait happens at the 9th falling edge.
- R8: `sda_pull` goes high at the 8th falling edge when an acknowledge is due and drops at the 9th. In a data byte it is due when ack-enable is 1. In an address byte ack-enable has no effect unless `ext_code` is 1.
- R9: `scl_hold` stays high until a `wait_release` pulse, and drops on the following clock.
- R10: A `start_det` or `stop_det` pulse clears `sda_pull`, `scl_hold` and the clock count, so the next falling edge is clock 1.
- R11: `irq` is high for exactly one system clock for each wait.
- R12: The wait-select and ack-enable bits change only on a cycle with `ctl_we`=1, which loads `ctl_wtim_d` and `ctl_acke_d`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| start_det | input | 1 | Start condition detected strobe |
| stop_det | input | 1 | Stop condition detected strobe |
| is_master | input | 1 | 1 when the controller is master |
| addr_phase | input | 1 | 1 during the address byte |
| addr_match | input | 1 | Own slave address recognised |
| ext_code | input | 1 | Extension code received |
| gen_call | input | 1 | General call address received |
| ctl_we | input | 1 | Control write strobe |
| ctl_wtim_d | input | 1 | Wait-select value to write (0: clock 8, 1: clock 9) |
| ctl_acke_d | input | 1 | Ack-enable value to write |
| wait_release | input | 1 | One-cycle strobe ending a wait |
| scl_hold | output | 1 | Hold SCL low |
| sda_pull | output | 1 | Drive SDA low (acknowledge) |
| irq | output | 1 | Byte-done interrupt pulse |

## Verification
The assertions check on every cycle that the interrupt is a single-cycle pulse that coincides with the start of a hold. They also check that a hold lasts until a release or a bus event, that start or stop clears the hold and the acknowledge, and that the control bits move only on a write. Which clock the wait lands on, how the address-phase, extension-code and general-call overrides resolve, and when the acknowledge window opens depend on counting SCL edges across a whole byte. Only the bench's byte scenarios show those, checked against its cycle model.

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_BITS   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic start_det,
  input  logic stop_det,
  input  logic is_master,
  input  logic addr_phase,
  input  logic addr_match,
  input  logic ext_code,
  input  logic gen_call,
  input  logic ctl_we,
  input  logic ctl_wtim_d,
  input  logic ctl_acke_d,
  input  logic wait_release,
  output logic scl_hold,
  output logic sda_pull,
  output logic irq
);
  localparam int ACK_CLK = DATA_BITS + 1;
  localparam int CNT_W   = $clog2(ACK_CLK + 1);

  logic [SYNC_STAGES:0] scl_sh;
  logic [CNT_W-1:0]     cnt;
  logic [CNT_W-1:0]     nth;
  logic                 wtim_q, acke_q;
  logic                 fall, at_data_end, at_ack_end;
  logic                 wait_data, wait_last, ack_want, take_wait, bus_evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) scl_sh <= '1;
    else        scl_sh <= {scl_sh[SYNC_STAGES-1:0], scl_in};

  assign fall        = scl_sh[SYNC_STAGES] & ~scl_sh[SYNC_STAGES-1];
  assign nth         = cnt + 1'b1;
  assign at_data_end = fall && (nth == CNT_W'(DATA_BITS));
  assign at_ack_end  = fall && (nth == CNT_W'(ACK_CLK));
  assign bus_evt     = start_det | stop_det;

  assign wait_data = addr_phase ? ext_code : ~wtim_q;
  assign wait_last = addr_phase ? (~ext_code & (is_master | addr_match | gen_call)) : wtim_q;
  assign ack_want  = addr_phase ? (ext_code ? acke_q : (~is_master & (addr_match | gen_call)))
                                : acke_q;
  assign take_wait = (at_data_end & wait_data) | (at_ack_end & wait_last);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wtim_q <= 1'b0;
      acke_q <= 1'b0;
    end else if (ctl_we) begin
      wtim_q <= ctl_wtim_d;
      acke_q <= ctl_acke_d;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt <= '0;
    else if (bus_evt) cnt <= '0;
    else if (fall)    cnt <= at_ack_end ? '0 : nth;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           sda_pull <= 1'b0;
    else if (bus_evt)     sda_pull <= 1'b0;
    else if (at_data_end) sda_pull <= ack_want;
    else if (at_ack_end)  sda_pull <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            scl_hold <= 1'b0;
    else if (bus_evt)      scl_hold <= 1'b0;
    else if (take_wait)    scl_hold <= 1'b1;
    else if (wait_release) scl_hold <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq <= 1'b0;
    else        irq <= take_wait & ~bus_evt;
endmodule

// File: rtl/i2c_byte_seq_chk.sv
module i2c_byte_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic irq,
  input logic scl_hold,
  input logic sda_pull,
  input logic wait_release,
  input logic start_det,
  input logic stop_det,
  input logic ctl_we,
  input logic wtim_q,
  input logic acke_q
);
  // R11
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> scl_hold);
  // R9
  hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(scl_hold) |-> irq);
  // R9
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold && !wait_release && !start_det && !stop_det) |=> scl_hold);
  // R9
  hold_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_release |=> (!scl_hold || irq));
  // R10
  bus_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> (!sda_pull && !scl_hold && !irq));
  // R12
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> ($stable(wtim_q) && $stable(acke_q)));
endmodule

bind i2c_byte_seq i2c_byte_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .scl_hold(scl_hold), .sda_pull(sda_pull),
  .wait_release(wait_release), .start_det(start_det), .stop_det(stop_det),
  .ctl_we(ctl_we), .wtim_q(wtim_q), .acke_q(acke_q)
);

// File: tb/sim_i2c_byte_seq.sv
module sim_i2c_byte_seq;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, scl_in = 1'b1, start_det = 1'b0, stop_det = 1'b0;
  logic is_master = 1'b0, addr_phase = 1'b0, addr_match = 1'b0, ext_code = 1'b0, gen_call = 1'b0;
  logic ctl_we = 1'b0, ctl_wtim_d = 1'b0, ctl_acke_d = 1'b0, wait_release = 1'b0;
  logic scl_hold, sda_pull, irq;

  i2c_byte_seq u0 (.*);

  int checks = 0, errors = 0;
  int fall_idx = 0, irq_cnt = 0, irq_at = 0;
  bit ack9 = 0, early = 0, irq_prev = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference
  bit m1 = 1, m2 = 1, m3 = 1, mw = 0, ma = 0, mh = 0, ms = 0, mi = 0;
  int mcnt = 0;
  always @(posedge clk) begin
    bit f, w8, w9, ak;
    int n;
    if (!rst_n) begin
      m1 = 1; m2 = 1; m3 = 1; mcnt = 0; mw = 0; ma = 0; mh = 0; ms = 0; mi = 0;
    end else begin
      f = m3 && !m2;
      n = mcnt + 1;
      mi = 0;
      if (addr_phase) begin
        w8 = ext_code;
        w9 = !ext_code && (is_master || addr_match || gen_call);
        ak = ext_code ? ma : (!is_master && (addr_match || gen_call));
      end else begin
        w8 = !mw; w9 = mw; ak = ma;
      end
      if (start_det || stop_det) begin
        mcnt = 0; ms = 0; mh = 0;
      end else begin
        if (wait_release) mh = 0;
        if (f) begin
          mcnt = (n == 9) ? 0 : n;
          if ((n == 8 && w8) || (n == 9 && w9)) begin mh = 1; mi = 1; end
          if (n == 8) ms = ak;
          if (n == 9) ms = 0;
        end
      end
      if (ctl_we) begin mw = ctl_wtim_d; ma = ctl_acke_d; end
      m3 = m2; m2 = m1; m1 = scl_in;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(irq == mi, "R11 irq vs model", irq, mi);
    chk(scl_hold == mh, "R9 scl_hold vs model", scl_hold, mh);
    chk(sda_pull == ms, "R8 sda_pull vs model", sda_pull, ms);
    if (irq) begin irq_cnt++; irq_at = fall_idx; end
    if (irq && irq_prev) chk(0, "R11 irq width", 2, 1);
    irq_prev = irq;
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic wr(bit w, bit a);
    ctl_wtim_d = w; ctl_acke_d = a; ctl_we = 1; cyc(1); ctl_we = 0; cyc(1);
  endtask

  task automatic bus_evt(bit stop);
    if (stop) stop_det = 1; else start_det = 1;
    cyc(1); start_det = 0; stop_det = 0; cyc(2);
  endtask

  task automatic clk_bit(int i);
    fall_idx = i; scl_in = 1; cyc(3);
    if (i == 9) ack9 |= sda_pull; else early |= sda_pull;
    cyc(3); scl_in = 0; cyc(6);
    if (scl_hold) begin
      cyc(4);
      chk(scl_hold, "R9 hold kept until release", scl_hold, 1);
      wait_release = 1; cyc(1); wait_release = 0; cyc(1);
      chk(!scl_hold, "R9 hold dropped after release", scl_hold, 0);
    end
  endtask

  task automatic byte_run(int n);
    irq_cnt = 0; irq_at = 0; ack9 = 0; early = 0;
    for (int i = 1; i <= n; i++) clk_bit(i);
    scl_in = 1; cyc(4);
  endtask

  task automatic mode(bit ap, bit ms_, bit am, bit ec, bit gc);
    addr_phase = ap; is_master = ms_; addr_match = am; ext_code = ec; gen_call = gc;
    bus_evt(0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(4); rst_n = 1; cyc(2);
    chk(!scl_hold && !sda_pull && !irq, "R1 reset outputs", {scl_hold, sda_pull, irq}, 0);

    mode(0, 0, 0, 0, 0); byte_run(9);
    chk(irq_at == 8 && irq_cnt == 1, "R1 default wait at clock 8", irq_at, 8);
    chk(!ack9, "R1 default no acknowledge", ack9, 0);
    chk(irq_cnt == 1, "R2 single interrupt per byte", irq_cnt, 1);

    wr(1, 1); mode(0, 0, 0, 0, 0); byte_run(9);
    chk(irq_at == 9 && irq_cnt == 1, "R3 wait at clock 9", irq_at, 9);
    chk(ack9 && !early, "R8 data acknowledge in clock 9", ack9, 1);
    chk(ack9, "R12 write loaded control bits", ack9, 1);

    wr(0, 1); mode(1, 1, 0, 0, 0); byte_run(9);
    chk(irq_at == 9 && irq_cnt == 1, "R4 master address wait at 9", irq_at, 9);
    chk(!ack9, "R8 master address ack-enable ignored", ack9, 0);

    mode(1, 0, 1, 0, 0); byte_run(9);
    chk(irq_at == 9 && irq_cnt == 1, "R5 matched slave wait at 9", irq_at, 9);
    chk(ack9 && !early, "R5 matched slave acknowledge", ack9, 1);

    mode(1, 0, 0, 0, 0); byte_run(9);
    chk(irq_cnt == 0, "R5 unmatched slave no interrupt", irq_cnt, 0);
    chk(!ack9, "R5 unmatched slave no acknowledge", ack9, 0);

    mode(1, 0, 0, 1, 0); byte_run(9);
    chk(irq_at == 8 && irq_cnt == 1, "R6 extension code wait at 8", irq_at, 8);
    chk(ack9, "R6 extension code ack follows enable 1", ack9, 1);
    wr(1, 0); mode(1, 0, 0, 1, 0); byte_run(9);
    chk(irq_at == 8 && irq_cnt == 1, "R6 extension code wait at 8 with select 1", irq_at, 8);
    chk(!ack9, "R6 extension code ack follows enable 0", ack9, 0);

    mode(1, 0, 0, 0, 1); byte_run(9);
    chk(irq_at == 9 && irq_cnt == 1, "R7 general call wait at 9", irq_at, 9);
    chk(ack9, "R7 general call acknowledge", ack9, 1);

    wr(1, 1); mode(0, 0, 0, 0, 0); byte_run(8);
    chk(sda_pull, "R8 acknowledge pending after clock 8", sda_pull, 1);
    bus_evt(1);
    chk(!sda_pull, "R10 stop clears acknowledge", sda_pull, 0);

    wr(0, 0); mode(0, 0, 0, 0, 0); byte_run(5); bus_evt(0); byte_run(9);
    chk(irq_at == 8 && irq_cnt == 1, "R10 start restarts clock count", irq_at, 8);

    ctl_wtim_d = 1; ctl_acke_d = 1; cyc(3);
    mode(0, 0, 0, 0, 0); byte_run(9);
    chk(irq_at == 8 && irq_cnt == 1, "R12 no write keeps wait select", irq_at, 8);
    chk(!ack9, "R12 no write keeps ack enable", ack9, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule